// File: doc/BRIEF.md
# Trimmed Sliding-Average Filter

This block smooths a stream of unsigned count samples, such as the pulse counts a frequency meter produces once per gate period. Every accepted sample enters a six-deep shift-register window and pushes the oldest one out. After each update, the block finds the single largest and the single smallest value in the window and drops them. It then sums the four values that remain and divides by four with a right shift. One isolated spike, high or low, therefore cannot move the result, and the output still follows slow trends because it is recomputed for every new sample.

The producer presents a sample with a one-cycle valid strobe, and there may be any number of idle cycles between strobes. The consumer receives the averaged count with its own one-cycle strobe, a fixed three cycles after the input strobe. Between strobes the output word holds its value. The reset input is active low and asynchronous, and the block releases it internally in step with the clock.

Top module: `tsa_filter`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_data is 0 until the first result is produced.
- R2: The window holds the six most recently accepted samples. Each accepted sample displaces the oldest, so every result is computed from exactly the latest six.
- R3: After reset, no out_valid is produced for the first five accepted samples. The sixth accepted sample produces the first result, and every accepted sample after that produces one result.
- R4: The result equals (sum of the six window samples minus their maximum minus their minimum) shifted right by 2, with the remainder discarded, so it always lies between the window minimum and maximum.
- R5: When several window samples share the maximum or the minimum value, exactly one instance of each is removed. A window of six equal values yields that value.
- R6: out_valid is a single-cycle pulse three clock cycles after the cycle in which in_valid is high. out_data changes only in cycles where out_valid is high.
- R7: While in_valid is 0, in_data is ignored and the window is left unchanged.
- R8: Six full-scale samples (all ones) give a full-scale result, with no overflow in the internal sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W (16) | Unsigned sample value |
| out_valid | output | 1 | Result strobe, three cycles after in_valid |
| out_data | output | DATA_W (16) | Trimmed average, held between strobes |

## Verification
Several properties are checked in every cycle: the output strobe never appears without an input strobe three cycles earlier, and never before six samples have arrived. The output word holds while no strobe is present. The window shifts by exactly one place per accepted sample and stays still otherwise. The registered minimum never exceeds the maximum, the trimmed sum never underflows, and the trimmed mean stays inside the [min, max] bracket. These checks cannot show that the arithmetic value is exactly right, that duplicated extremes lose only one instance each, or that the fill count restarts after a second reset. The bench shows those by comparing every result against its own window model, across directed ties, full-scale values, spikes, idle gaps carrying garbage data, and random streams.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  localparam int DATA_W_DEF = 16;
  localparam int WIN_DEF    = 6;

  // samples that survive trimming (one max, one min removed)
  function automatic int keep_count(input int win);
    return win - 2;
  endfunction

  // right-shift amount that divides by the survivor count
  function automatic int trim_shift(input int win);
    return $clog2(win - 2);
  endfunction

  // width that holds the sum of every window sample
  function automatic int sum_width(input int dw, input int win);
    return dw + $clog2(win);
  endfunction

  function automatic int fill_width(input int win);
    return $clog2(win + 1);
  endfunction

endpackage

// File: rtl/tsa_rst_sync.sv
module tsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/tsa_window.sv
module tsa_window
  import tsa_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int WIN    = WIN_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [DATA_W-1:0]     din,
  output logic [WIN*DATA_W-1:0] win_flat,
  output logic                  full_push
);

  localparam int CNT_W = fill_width(WIN);

  logic [DATA_W-1:0] win_q [WIN];
  logic [DATA_W-1:0] win_d [WIN];
  logic [CNT_W-1:0]  fill_q;
  logic [CNT_W-1:0]  fill_d;
  logic              fp_q;
  logic              fp_d;

  // next state: stage 0 takes the new sample, others take their neighbour
  always_comb begin
    win_d[0] = push ? din : win_q[0];
  end

  for (genvar g = 1; g < WIN; g++) begin : g_stage
    always_comb begin
      win_d[g] = push ? win_q[g-1] : win_q[g];
    end
  end

  always_comb begin
    fill_d = fill_q;
    if (push && (fill_q != CNT_W'(WIN))) begin
      fill_d = fill_q + 1'b1;
    end
    fp_d = push && (fill_q >= CNT_W'(WIN - 1));
  end

  for (genvar g = 0; g < WIN; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[g] <= '0;
      end else if (push) begin
        win_q[g] <= win_d[g];
      end
    end
    assign win_flat[g*DATA_W +: DATA_W] = win_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      fp_q   <= 1'b0;
    end else begin
      if (push) begin
        fill_q <= fill_d;
      end
      fp_q <= fp_d;
    end
  end

  assign full_push = fp_q;

  AST_FILL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(WIN)); // R3
  AST_WIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (win_q[1] == $past(win_q[0]))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(win_q[0])); // R7

endmodule

// File: rtl/tsa_extrema.sv
module tsa_extrema
  import tsa_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int WIN    = WIN_DEF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic [WIN*DATA_W-1:0]            win_flat,
  output logic [DATA_W-1:0]                max_o,
  output logic [DATA_W-1:0]                min_o,
  output logic [sum_width(DATA_W,WIN)-1:0] sum_o,
  output logic                             vld_o
);

  localparam int SUM_W = sum_width(DATA_W, WIN);
  localparam int PAD_W = SUM_W - DATA_W;

  logic [DATA_W-1:0] w [WIN];
  logic [DATA_W-1:0] max_c;
  logic [DATA_W-1:0] min_c;
  logic [SUM_W-1:0]  sum_c;
  logic [DATA_W-1:0] max_q;
  logic [DATA_W-1:0] min_q;
  logic [SUM_W-1:0]  sum_q;
  logic              vld_q;

  for (genvar g = 0; g < WIN; g++) begin : g_unpack
    assign w[g] = win_flat[g*DATA_W +: DATA_W];
  end

  // linear compare chain and total across the whole window
  always_comb begin
    max_c = w[0];
    min_c = w[0];
    sum_c = {{PAD_W{1'b0}}, w[0]};
    for (int i = 1; i < WIN; i++) begin
      if (w[i] > max_c) max_c = w[i];
      if (w[i] < min_c) min_c = w[i];
      sum_c = sum_c + {{PAD_W{1'b0}}, w[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      min_q <= '0;
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (en) begin
        max_q <= max_c;
        min_q <= min_c;
        sum_q <= sum_c;
      end
      vld_q <= en;
    end
  end

  assign max_o = max_q;
  assign min_o = min_q;
  assign sum_o = sum_q;
  assign vld_o = vld_q;

  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (min_q <= max_q)); // R5

endmodule

// File: rtl/tsa_trim.sv
module tsa_trim
  import tsa_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int WIN    = WIN_DEF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vld_i,
  input  logic [DATA_W-1:0]                max_i,
  input  logic [DATA_W-1:0]                min_i,
  input  logic [sum_width(DATA_W,WIN)-1:0] sum_i,
  output logic                             out_valid,
  output logic [DATA_W-1:0]                out_data
);

  localparam int SUM_W = sum_width(DATA_W, WIN);
  localparam int SHIFT = trim_shift(WIN);
  localparam int PAD_W = SUM_W - DATA_W;

  logic [SUM_W-1:0]  ext_max;
  logic [SUM_W-1:0]  ext_min;
  logic [SUM_W-1:0]  trimmed;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_comb begin
    ext_max = {{PAD_W{1'b0}}, max_i};
    ext_min = {{PAD_W{1'b0}}, min_i};
    trimmed = sum_i - ext_max - ext_min;
    data_d  = vld_i ? trimmed[SHIFT +: DATA_W] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (vld_i) begin
        data_q <= data_d;
      end
      valid_q <= vld_i;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (sum_i >= ext_max + ext_min)); // R8
  AST_MEAN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (((ext_min << SHIFT) <= trimmed) && (trimmed <= (ext_max << SHIFT)))); // R4

endmodule

// File: rtl/tsa_filter.sv
module tsa_filter
  import tsa_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int WIN    = WIN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int SUM_W = sum_width(DATA_W, WIN);
  localparam int CNT_W = fill_width(WIN);

  logic                  rst_sync_n;
  logic [WIN*DATA_W-1:0] win_flat;
  logic                  full_push;
  logic [DATA_W-1:0]     max_w;
  logic [DATA_W-1:0]     min_w;
  logic [SUM_W-1:0]      sum_w;
  logic                  ext_vld;

  tsa_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsa_window #(.DATA_W(DATA_W), .WIN(WIN)) u_window (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (in_valid),
    .din       (in_data),
    .win_flat  (win_flat),
    .full_push (full_push)
  );

  tsa_extrema #(.DATA_W(DATA_W), .WIN(WIN)) u_extrema (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (full_push),
    .win_flat (win_flat),
    .max_o    (max_w),
    .min_o    (min_w),
    .sum_o    (sum_w),
    .vld_o    (ext_vld)
  );

  tsa_trim #(.DATA_W(DATA_W), .WIN(WIN)) u_trim (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .vld_i     (ext_vld),
    .max_i     (max_w),
    .min_i     (min_w),
    .sum_i     (sum_w),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // independent count of accepted strobes, used only by the fill check
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seen_q <= '0;
    end else if (in_valid && (seen_q != CNT_W'(WIN))) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (seen_q == CNT_W'(WIN))); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(in_valid, 3)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(out_data)); // R6

endmodule

// File: tb/tsa_filter_tb.sv
module tsa_filter_tb;

  localparam int DW  = 16;
  localparam int WN  = 6;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  int    mwin [WN];
  int    mcnt = 0;
  int    q_dat [$];
  int    q_cyc [$];
  string q_tag [$];
  int    last_out = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsa_filter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic int model_result();
    int s, mx, mn;
    s = 0; mx = mwin[0]; mn = mwin[0];
    for (int i = 0; i < WN; i++) begin
      s += mwin[i];
      if (mwin[i] > mx) mx = mwin[i];
      if (mwin[i] < mn) mn = mwin[i];
    end
    return (s - mx - mn) >> 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one cycle of stimulus; valid samples update the bench window model
  task automatic drive(input bit v, input int d, input string tag);
    @(negedge clk);
    in_valid = v;
    in_data  = DW'(d);
    if (v) begin
      for (int i = WN - 1; i > 0; i--) mwin[i] = mwin[i-1];
      mwin[0] = d;
      if (mcnt < WN) mcnt++;
      if (mcnt == WN) begin
        q_dat.push_back(model_result());
        q_cyc.push_back(cyc + LAT);
        q_tag.push_back(tag);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, int'($urandom_range(0, 65535)), "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 data in reset", int'(out_data), 0);
    mcnt = 0;
    for (int i = 0; i < WN; i++) mwin[i] = 0;
    last_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 data after reset", int'(out_data), 0);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        nchk++; nfail++;
        $display("FAIL R6: missing result, actual 0 expected %0d", q_dat[0]);
        void'(q_dat.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
      if (out_valid) begin
        if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
          check(q_tag[0], int'(out_data), q_dat[0]);
          void'(q_dat.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end else begin
          check("R3 unexpected out_valid", 1, 0);
        end
        last_out = int'(out_data);
      end else begin
        check("R6 hold", int'(out_data), last_out);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WN; i++) mwin[i] = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // R3: five samples give nothing, the sixth gives (210-60-10)/4 = 35
    drive(1'b1, 10, "R3"); drive(1'b1, 20, "R3"); drive(1'b1, 30, "R3");
    drive(1'b1, 40, "R3"); drive(1'b1, 50, "R3");
    idle(6);
    drive(1'b1, 60, "R3 first result");
    idle(5);

    // R5: ties on both extremes, then a flat window
    drive(1'b1, 9, "R5"); drive(1'b1, 9, "R5"); drive(1'b1, 5, "R5");
    drive(1'b1, 5, "R5"); drive(1'b1, 7, "R5"); drive(1'b1, 9, "R5");
    for (int i = 0; i < WN; i++) drive(1'b1, 77, "R5 flat");
    idle(4);

    // R8: full scale
    for (int i = 0; i < WN; i++) drive(1'b1, 65535, "R8 full scale");
    idle(4);

    // R4: spike rejection and truncation
    for (int i = 0; i < WN - 1; i++) drive(1'b1, 100, "R4 spike");
    drive(1'b1, 60000, "R4 spike");
    drive(1'b1, 0, "R4 low spike");
    drive(1'b1, 1, "R4 trunc"); drive(1'b1, 2, "R4 trunc"); drive(1'b1, 2, "R4 trunc");
    drive(1'b1, 3, "R4 trunc"); drive(1'b1, 8, "R4 trunc");
    idle(4);

    // R2/R7: random stream, gaps carry garbage on in_data
    for (int n = 0; n < 400; n++) begin
      bit gap;
      int d;
      gap = ($urandom_range(0, 3) == 0);
      if (gap) idle(int'($urandom_range(1, 3)));
      if ($urandom_range(0, 1) == 0) d = int'($urandom_range(1000, 1006));
      else d = int'($urandom_range(0, 65535));
      drive(1'b1, d, gap ? "R7 after gap" : "R2 sliding");
    end
    idle(6);

    // R1/R3 again: second reset restarts the fill count
    do_reset();
    for (int i = 0; i < WN - 1; i++) drive(1'b1, 500 + i * 3, "R3 refill");
    idle(8);
    drive(1'b1, 4000, "R3 refill first");
    idle(6);

    check("R6 all results delivered", q_dat.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule